// File: doc/BRIEF.md
# Dual Cascadable Compare-Match Timer

This block holds two 8-bit counting channels. Each channel has its own counter, two compare values (A and B), a control register and a clock-select register. A shared free-running prescaler produces one-cycle count enables at several divide ratios, and each channel picks one of them. When a counter step lands on a compare value, the channel raises a one-cycle interrupt pulse if that interrupt is enabled. The same happens when the counter wraps past its top value. The counter can also be set to return to zero on a compare match, so it runs with a fixed period.

The channels can be linked in two ways. In the first, channel 1 counts the compare-A matches of channel 0. In the second, the two channels form one 16-bit counter: channel 0 is the upper byte and channel 1 the lower byte. In that case the 16-bit counter uses channel 1's clock selection, and its compare, clear and interrupt logic belong to channel 0. Software reaches every register through a per-register, per-channel write strobe and a shared data input.

Top module: `twin_match_timer`

## Requirements
- R1: After reset, both counters read 0, all interrupt outputs are low, both compare values of each channel are 0xFF, and both clock-select registers are 0.
- R2: A channel's counter holds its value when bits 4:3 of its clock-select register are 0 (external pin, not modelled) or 2 (reserved). It also holds when those bits are 1 and the divider code in bits 2:0 is 0.
- R3: When the source field is 1, divider codes 1 to 7 advance the counter once every 1, 2, 8, 32, 64, 1024 and 8192 clocks respectively.
- R4: When a counter step makes the counter equal to compare A, irq_cmpa_o of that channel is high for exactly the one cycle after that clock edge, provided control bit 6 is set. If bit 6 is clear, there is no pulse.
- R5: Compare B behaves the same way on irq_cmpb_o, gated by control bit 7.
- R6: A step from the counter's maximum value wraps it to 0 and pulses irq_ovf_o for one cycle if control bit 5 is set.
- R7: Control bits 3:2 select the clear behaviour. With 1, a compare-A match loads 0 instead of the match value. With 2, a compare-B match does the same. With 0 or 3, the counter never clears on a match.
- R8: When channel 1's source field is 3 and channel 0's is not, channel 1 advances by one on each compare-A match of channel 0. This happens whether or not channel 0's compare-A interrupt is enabled.
- R9: When channel 0's source field is 3, {count0, count1} forms one 16-bit counter. It steps on channel 1's clock selection and compares against {cmpA0, cmpA1} and {cmpB0, cmpB1}. It wraps past 0xFFFF, clears according to channel 0's clear field, and reports on channel 0's interrupt outputs using channel 0's enables. Channel 1's interrupt outputs stay low.
- R10: A counter write loads wdata_i at that clock edge and takes priority over any count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdata_i | input | CNT_W | Shared write data |
| we_ctrl_i | input | 2 | Control register write strobe, one per channel (bit 7 B enable, 6 A enable, 5 overflow enable, 3:2 clear mode) |
| we_cmpa_i | input | 2 | Compare A write strobe per channel |
| we_cmpb_i | input | 2 | Compare B write strobe per channel |
| we_cnt_i | input | 2 | Counter write strobe per channel |
| we_clk_i | input | 2 | Clock-select write strobe per channel (bits 4:3 source, 2:0 divider code) |
| cnt0_o | output | CNT_W | Channel 0 counter |
| cnt1_o | output | CNT_W | Channel 1 counter |
| irq_cmpa_o | output | 2 | Compare-A interrupt pulse per channel |
| irq_cmpb_o | output | 2 | Compare-B interrupt pulse per channel |
| irq_ovf_o | output | 2 | Overflow interrupt pulse per channel |

## Verification
The bench uses the defaults: CNT_W of 8 and a 13-bit prescaler. With these values the slowest divider, 8192, can be measured over a window of two count steps. The 8-bit wrap and the 16-bit cascade wrap are reached within a few clocks by preloading the counters. With the narrow counter, clear-on-match periods of 3 to 5 counts fit inside short windows, so the bench can count each interrupt pulse exactly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        SRC_PIN   = 2'd0,
        SRC_INT   = 2'd1,
        SRC_RSV   = 2'd2,
        SRC_CHAIN = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        CLR_NONE  = 2'd0,
        CLR_ON_A  = 2'd1,
        CLR_ON_B  = 2'd2,
        CLR_NONE3 = 2'd3
    } clr_e;

    typedef struct packed {
        logic en_b;
        logic en_a;
        logic en_o;
        clr_e clr;
    } ctl_t;

    typedef struct packed {
        src_e       src;
        logic [2:0] div;
    } cks_t;

    localparam int NUM_CODES = 8;

    // number of low prescaler bits that must be all ones for a tap to fire
    function automatic int tap_shift(input logic [2:0] code);
        case (code)
            3'd2:    return 1;
            3'd3:    return 3;
            3'd4:    return 5;
            3'd5:    return 6;
            3'd6:    return 10;
            3'd7:    return 13;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PRE_W = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [NUM_CODES-1:0] tick_o
);

    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // code 0 never ticks: the counter is stopped
    assign tick_o[0] = 1'b0;

    for (genvar c = 1; c < NUM_CODES; c++) begin : g_tap
        localparam int               SH  = tap_shift(3'(c));
        localparam logic [PRE_W-1:0] MSK = PRE_W'((64'd1 << SH) - 64'd1);
        assign tick_o[c] = ((pre_q & MSK) == MSK);
    end

    // R3
    tap_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o[7] |=> !tick_o[7]);

endmodule

// File: rtl/tmr_event_unit.sv
module tmr_event_unit
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         adv_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] cmpa_i,
    input  logic [W-1:0] cmpb_i,
    input  clr_e         clr_i,
    output logic [W-1:0] nxt_o,
    output logic         hit_a_o,
    output logic         hit_b_o,
    output logic         hit_o_o
);

    logic [W-1:0] inc;
    logic         do_clear;

    always_comb begin
        inc      = cnt_i + 1'b1;
        hit_a_o  = adv_i && (inc == cmpa_i);
        hit_b_o  = adv_i && (inc == cmpb_i);
        hit_o_o  = adv_i && (cnt_i == {W{1'b1}});
        do_clear = ((clr_i == CLR_ON_A) && hit_a_o) ||
                   ((clr_i == CLR_ON_B) && hit_b_o);
        if (!adv_i)        nxt_o = cnt_i;
        else if (do_clear) nxt_o = '0;
        else               nxt_o = inc;
    end

endmodule

// File: rtl/twin_match_timer.sv
module twin_match_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [1:0]       we_ctrl_i,
    input  logic [1:0]       we_cmpa_i,
    input  logic [1:0]       we_cmpb_i,
    input  logic [1:0]       we_cnt_i,
    input  logic [1:0]       we_clk_i,
    output logic [CNT_W-1:0] cnt0_o,
    output logic [CNT_W-1:0] cnt1_o,
    output logic [1:0]       irq_cmpa_o,
    output logic [1:0]       irq_cmpb_o,
    output logic [1:0]       irq_ovf_o
);

    localparam int NCH    = 2;
    localparam int WIDE_W = 2 * CNT_W;

    typedef struct packed {
        ctl_t [NCH-1:0]            ctl;
        cks_t [NCH-1:0]            cks;
        logic [NCH-1:0][CNT_W-1:0] cnt;
        logic [NCH-1:0][CNT_W-1:0] cmpa;
        logic [NCH-1:0][CNT_W-1:0] cmpb;
        logic [NCH-1:0]            ia;
        logic [NCH-1:0]            ib;
        logic [NCH-1:0]            io;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_CODES-1:0] tick;
    logic                 chain_mode;
    logic                 adv0, adv1, adv_w;
    logic [CNT_W-1:0]     nxt0, nxt1;
    logic                 a0, b0, o0, a1, b1, o1;
    logic [WIDE_W-1:0]    nxt_w;
    logic                 aw, bw, ow;

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    assign chain_mode = (s_q.cks[0].src == SRC_CHAIN);
    assign adv0  = (s_q.cks[0].src == SRC_INT) && tick[s_q.cks[0].div];
    assign adv_w = (s_q.cks[1].src == SRC_INT) && tick[s_q.cks[1].div];
    assign adv1  = adv_w || ((s_q.cks[1].src == SRC_CHAIN) && a0);

    tmr_event_unit #(.W(CNT_W)) u_ev0 (
        .adv_i   (adv0),
        .cnt_i   (s_q.cnt[0]),
        .cmpa_i  (s_q.cmpa[0]),
        .cmpb_i  (s_q.cmpb[0]),
        .clr_i   (s_q.ctl[0].clr),
        .nxt_o   (nxt0),
        .hit_a_o (a0),
        .hit_b_o (b0),
        .hit_o_o (o0)
    );

    tmr_event_unit #(.W(CNT_W)) u_ev1 (
        .adv_i   (adv1),
        .cnt_i   (s_q.cnt[1]),
        .cmpa_i  (s_q.cmpa[1]),
        .cmpb_i  (s_q.cmpb[1]),
        .clr_i   (s_q.ctl[1].clr),
        .nxt_o   (nxt1),
        .hit_a_o (a1),
        .hit_b_o (b1),
        .hit_o_o (o1)
    );

    tmr_event_unit #(.W(WIDE_W)) u_evw (
        .adv_i   (adv_w),
        .cnt_i   ({s_q.cnt[0], s_q.cnt[1]}),
        .cmpa_i  ({s_q.cmpa[0], s_q.cmpa[1]}),
        .cmpb_i  ({s_q.cmpb[0], s_q.cmpb[1]}),
        .clr_i   (s_q.ctl[0].clr),
        .nxt_o   (nxt_w),
        .hit_a_o (aw),
        .hit_b_o (bw),
        .hit_o_o (ow)
    );

    always_comb begin
        s_d    = s_q;
        s_d.ia = '0;
        s_d.ib = '0;
        s_d.io = '0;

        if (chain_mode) begin
            {s_d.cnt[0], s_d.cnt[1]} = nxt_w;
            s_d.ia[0] = aw && s_q.ctl[0].en_a;
            s_d.ib[0] = bw && s_q.ctl[0].en_b;
            s_d.io[0] = ow && s_q.ctl[0].en_o;
        end else begin
            s_d.cnt[0] = nxt0;
            s_d.cnt[1] = nxt1;
            s_d.ia     = {a1 && s_q.ctl[1].en_a, a0 && s_q.ctl[0].en_a};
            s_d.ib     = {b1 && s_q.ctl[1].en_b, b0 && s_q.ctl[0].en_b};
            s_d.io     = {o1 && s_q.ctl[1].en_o, o0 && s_q.ctl[0].en_o};
        end

        for (int c = 0; c < NCH; c++) begin
            if (we_cnt_i[c])  s_d.cnt[c]  = wdata_i;
            if (we_cmpa_i[c]) s_d.cmpa[c] = wdata_i;
            if (we_cmpb_i[c]) s_d.cmpb[c] = wdata_i;
            if (we_ctrl_i[c]) begin
                s_d.ctl[c].en_b = wdata_i[7];
                s_d.ctl[c].en_a = wdata_i[6];
                s_d.ctl[c].en_o = wdata_i[5];
                s_d.ctl[c].clr  = clr_e'(wdata_i[3:2]);
            end
            if (we_clk_i[c]) begin
                s_d.cks[c].src = src_e'(wdata_i[4:3]);
                s_d.cks[c].div = wdata_i[2:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.cmpa <= '1;
            s_q.cmpb <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt0_o     = s_q.cnt[0];
    assign cnt1_o     = s_q.cnt[1];
    assign irq_cmpa_o = s_q.ia;
    assign irq_cmpb_o = s_q.ib;
    assign irq_ovf_o  = s_q.io;

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_cnt_i[1] && (s_q.cks[1].src == SRC_PIN || s_q.cks[1].src == SRC_RSV))
        |=> $stable(cnt1_o));

    // R4
    irq_a_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cmpa_o[0] |-> $past(s_q.ctl[0].en_a));

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ovf_o[0] && $past(!we_cnt_i[0] && !we_cnt_i[1])) |-> (cnt0_o == '0));

    // R7
    clear_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cmpa_o[0] && $past(!chain_mode && !we_cnt_i[0] && s_q.ctl[0].clr == CLR_ON_A))
        |-> (cnt0_o == '0));

    // R9
    chain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_mode |=> (irq_cmpa_o[1] == 1'b0 && irq_cmpb_o[1] == 1'b0 && irq_ovf_o[1] == 1'b0));

endmodule

// File: tb/twin_match_timer_bench.sv
module twin_match_timer_bench;

    localparam real CLK_HALF = 2.5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wdata = '0;
    logic [1:0] we_ctrl = '0, we_cmpa = '0, we_cmpb = '0, we_cnt = '0, we_clk = '0;
    logic [7:0] cnt0, cnt1;
    logic [1:0] irq_a, irq_b, irq_o;

    int checks = 0;
    int failures = 0;
    int pa [2];
    int pb [2];
    int po [2];

    always #(CLK_HALF) clk = ~clk;

    twin_match_timer u_twin_match_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wdata_i    (wdata),
        .we_ctrl_i  (we_ctrl),
        .we_cmpa_i  (we_cmpa),
        .we_cmpb_i  (we_cmpb),
        .we_cnt_i   (we_cnt),
        .we_clk_i   (we_clk),
        .cnt0_o     (cnt0),
        .cnt1_o     (cnt1),
        .irq_cmpa_o (irq_a),
        .irq_cmpb_o (irq_b),
        .irq_ovf_o  (irq_o)
    );

    typedef struct packed {
        logic [7:0] cmpa;
        logic [7:0] cmpb;
        logic [7:0] ctl;
        logic [7:0] start;
        int         steps;
        logic [7:0] exp_cnt;
        int         exp_a;
        int         exp_b;
        int         exp_o;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VEC [NVEC] = '{
        '{8'h05, 8'hFF, 8'hE4, 8'h00, 12, 8'h02, 2, 0, 0},
        '{8'h10, 8'h03, 8'hE8, 8'h00, 10, 8'h01, 0, 3, 0},
        '{8'h02, 8'hFC, 8'hE0, 8'hFA, 10, 8'h04, 1, 1, 1},
        '{8'h04, 8'hFF, 8'h04, 8'h00,  9, 8'h01, 0, 0, 0},
        '{8'h03, 8'hFF, 8'h4C, 8'h00,  7, 8'h07, 1, 0, 0}
    };

    localparam int SEL_CTL = 0, SEL_CA = 1, SEL_CB = 2, SEL_CNT = 3, SEL_CLK = 4;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int ch, input logic [7:0] v);
        @(negedge clk);
        wdata = v;
        case (sel)
            SEL_CTL: we_ctrl[ch] = 1'b1;
            SEL_CA:  we_cmpa[ch] = 1'b1;
            SEL_CB:  we_cmpb[ch] = 1'b1;
            SEL_CNT: we_cnt[ch]  = 1'b1;
            default: we_clk[ch]  = 1'b1;
        endcase
        @(negedge clk);
        we_ctrl = '0; we_cmpa = '0; we_cmpb = '0; we_cnt = '0; we_clk = '0;
    endtask

    task automatic clear_pulses();
        for (int c = 0; c < 2; c++) begin
            pa[c] = 0; pb[c] = 0; po[c] = 0;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int c = 0; c < 2; c++) begin
                pa[c] += int'(irq_a[c]);
                pb[c] += int'(irq_b[c]);
                po[c] += int'(irq_o[c]);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int c0;
        clear_pulses();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(cnt0 == 8'h00 && cnt1 == 8'h00, "R1", "counters after reset", {cnt0, cnt1}, 0);
        chk(irq_a == 0 && irq_b == 0 && irq_o == 0, "R1", "irqs after reset", {irq_a, irq_b, irq_o}, 0);
        // R1 compare A resets to 0xFF: count FD->FF hits it
        wr(SEL_CTL, 0, 8'h40);
        wr(SEL_CNT, 0, 8'hFD);
        clear_pulses();
        wr(SEL_CLK, 0, 8'h09);
        run(2);
        chk(pa[0] == 1 && cnt0 == 8'hFF, "R1", "reset compare A is FF", pa[0], 1);

        // R2 hold cases
        wr(SEL_CLK, 0, 8'h01);
        c0 = int'(cnt0);
        run(20);
        chk(int'(cnt0) == c0, "R2", "source pin holds", cnt0, c0);
        wr(SEL_CLK, 0, 8'h11);
        run(20);
        chk(int'(cnt0) == c0, "R2", "source reserved holds", cnt0, c0);
        wr(SEL_CLK, 0, 8'h08);
        run(20);
        chk(int'(cnt0) == c0, "R2", "divider code 0 holds", cnt0, c0);

        // main table (R4 R5 R6 R7), divide by 1
        for (int v = 0; v < NVEC; v++) begin
            wr(SEL_CLK, 0, 8'h00);
            wr(SEL_CA, 0, VEC[v].cmpa);
            wr(SEL_CB, 0, VEC[v].cmpb);
            wr(SEL_CTL, 0, VEC[v].ctl);
            wr(SEL_CNT, 0, VEC[v].start);
            clear_pulses();
            wr(SEL_CLK, 0, 8'h09);
            run(VEC[v].steps);
            chk(cnt0 == VEC[v].exp_cnt, "R7", $sformatf("vector %0d count", v), cnt0, VEC[v].exp_cnt);
            chk(pa[0] == VEC[v].exp_a, "R4", $sformatf("vector %0d compare A pulses", v), pa[0], VEC[v].exp_a);
            chk(pb[0] == VEC[v].exp_b, "R5", $sformatf("vector %0d compare B pulses", v), pb[0], VEC[v].exp_b);
            chk(po[0] == VEC[v].exp_o, "R6", $sformatf("vector %0d overflow pulses", v), po[0], VEC[v].exp_o);
        end

        // R3 divider ratios
        wr(SEL_CLK, 0, 8'h00);
        wr(SEL_CTL, 0, 8'h00);
        for (int code = 2; code < 8; code++) begin
            int div;
            int k;
            case (code)
                2: div = 2;
                3: div = 8;
                4: div = 32;
                5: div = 64;
                6: div = 1024;
                default: div = 8192;
            endcase
            k = (div > 64) ? 2 : 4;
            wr(SEL_CLK, 0, 8'h00);
            wr(SEL_CNT, 0, 8'h00);
            wr(SEL_CLK, 0, 8'h08 | 8'(code));
            c0 = int'(cnt0);
            run(div * k);
            chk(int'(cnt0) - c0 == k, "R3", $sformatf("divider code %0d steps", code), int'(cnt0) - c0, k);
        end

        // R8 channel 1 counts channel 0 compare-A matches
        wr(SEL_CLK, 0, 8'h00);
        wr(SEL_CTL, 0, 8'h04);
        wr(SEL_CA, 0, 8'h03);
        wr(SEL_CNT, 0, 8'h00);
        wr(SEL_CLK, 1, 8'h18);
        wr(SEL_CNT, 1, 8'h00);
        clear_pulses();
        wr(SEL_CLK, 0, 8'h09);
        run(9);
        chk(cnt1 == 8'h03, "R8", "channel 1 match count", cnt1, 3);
        chk(cnt0 == 8'h00 && pa[0] == 0, "R8", "channel 0 cleared, irq off", {cnt0, 8'(pa[0])}, 0);

        // R9 cascade: compare A across byte boundary
        wr(SEL_CLK, 1, 8'h00);
        wr(SEL_CLK, 0, 8'h00);
        wr(SEL_CTL, 0, 8'hE0);
        wr(SEL_CTL, 1, 8'hE0);
        wr(SEL_CA, 0, 8'h01);
        wr(SEL_CA, 1, 8'h02);
        wr(SEL_CB, 0, 8'hFF);
        wr(SEL_CB, 1, 8'hFF);
        wr(SEL_CNT, 0, 8'h00);
        wr(SEL_CNT, 1, 8'hFD);
        wr(SEL_CLK, 0, 8'h18);
        clear_pulses();
        wr(SEL_CLK, 1, 8'h09);
        run(5);
        chk({cnt0, cnt1} == 16'h0102, "R9", "16-bit count carry", {cnt0, cnt1}, 16'h0102);
        chk(pa[0] == 1, "R9", "16-bit compare A pulse", pa[0], 1);
        // R9 wrap past FFFF
        wr(SEL_CLK, 1, 8'h00);
        wr(SEL_CNT, 0, 8'hFF);
        wr(SEL_CNT, 1, 8'hFE);
        wr(SEL_CLK, 1, 8'h09);
        run(3);
        chk({cnt0, cnt1} == 16'h0001, "R9", "16-bit wrap count", {cnt0, cnt1}, 1);
        chk(po[0] == 1 && pb[0] == 1, "R9", "16-bit overflow and compare B", {po[0][7:0], pb[0][7:0]}, 16'h0101);
        // R9 clear on 16-bit compare A
        wr(SEL_CLK, 1, 8'h00);
        wr(SEL_CTL, 0, 8'hE4);
        wr(SEL_CA, 0, 8'h00);
        wr(SEL_CA, 1, 8'h04);
        wr(SEL_CNT, 0, 8'h00);
        wr(SEL_CNT, 1, 8'h00);
        pa[0] = 0;
        wr(SEL_CLK, 1, 8'h09);
        run(10);
        chk({cnt0, cnt1} == 16'h0002 && pa[0] == 2, "R9", "16-bit clear on A", {cnt0, cnt1}, 2);
        chk(pa[1] == 0 && pb[1] == 0 && po[1] == 0, "R9", "channel 1 irqs silent", pa[1] + pb[1] + po[1], 0);

        // R10 counter write priority
        wr(SEL_CLK, 1, 8'h00);
        wr(SEL_CLK, 0, 8'h00);
        wr(SEL_CTL, 0, 8'h00);
        wr(SEL_CNT, 0, 8'h00);
        wr(SEL_CLK, 0, 8'h09);
        run(5);
        wr(SEL_CNT, 0, 8'h40);
        chk(cnt0 == 8'h40, "R10", "write wins over step", cnt0, 8'h40);
        run(1);
        chk(cnt0 == 8'h41, "R10", "count resumes after write", cnt0, 8'h41);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule